// File: doc/BRIEF.md
# Triggered Fractional Rate Divider

This block sets the rate of a derived clock. It picks one of several parent tick streams, passes it through an optional integer pre-divider, and then through a main divider whose divisor has integer and fractional bits. The result is a stream of one-cycle enable pulses on `tick_o`, timed by the block's own reference clock. There is no gating cell and no real clock mux. Each parent is an enable input that is high in the reference cycles where that parent would have an edge.

Software works through three 32-bit registers that use a simple write/read port. Writes to the source and divider registers only stage new values. Those values take effect when software writes a 1 to a trigger bit. That bit reads 1 while the commit is pending and reads 0 once the new values are live. There are two triggers. One commits the source selection and the pre-divider. The other commits the main divider. All updates are refused while the derived clock is reported as off.

Top module: `trig_frac_clkdiv`

## Requirements
- R1: The main divider field holds the divisor minus one. Field 0 passes every pre-divided tick. Field 16 (divisor 3.0) passes one tick in three.
- R2: The main divider field is 8 bits wide at bit 4 of register 1. Its lowest 3 bits are fractional. The added one goes to the integer part, so the scaled divisor is field + 8. Field 8 means divisor 2.0.
- R3: Starting from a cleared state, N pre-divided ticks give floor(N*8 / (field+8)) output pulses. For example, field 4 (divisor 1.5) gives 26 pulses for 40 ticks.
- R4: Writing register 2 starts a commit for each bit set: bit 0 is the source trigger and bit 1 is the main trigger. That bit reads 1 in the three cycles after the write. It reads 0 from the fourth cycle on, and the staged values are live from that point.
- R5: The source trigger commits only the selection and the pre-divider. The main trigger commits only the main divider. A staged value whose trigger has not fired has no effect on the output.
- R6: While `clk_on_i` is 0, writes to registers 0 and 1 are dropped. A trigger write is also dropped, and its bit reads 0 in the very next cycle.
- R7: Register 0 holds the 2-bit selection at bit 4. A selection code of 3 or above names no parent, and no output pulses occur while it is active. The selection resets to 3.
- R8: Only the parent tick input at the index of the active selection drives the output. Ticks on the other parents have no effect.
- R9: The pre-divider field is 4 bits wide at bit 8 of register 0. It produces one tick for every field+1 ticks of the selected parent.
- R10: After reset, register 0 reads 0x30, registers 1 and 2 read 0, and `tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_on_i | input | 1 | Derived clock is enabled; updates are accepted only while this is high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 source, 1 divider, 2 trigger |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data; staged fields, or trigger busy bits |
| par_tick_i | input | 3 | One enable input per parent rate |
| tick_o | output | 1 | Divided enable pulse, one reference cycle wide |

## Verification
The assertions take the parent tick inputs as single-cycle enables that are synchronous to the reference clock. They also assume that staged divider values only change under the register port. The accumulator bound holds only because every main-divider change arrives together with a clear of the accumulator. The stimulus sends a trigger before each measured window, so pre-divider and accumulator phases start from zero. Where a window follows without a fresh commit, it uses tick counts that return both counters to zero, which keeps the expected pulse count exact.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_SRC  = 2'd0,
        A_DIV  = 2'd1,
        A_TRIG = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic src;
        logic main;
    } trig_pair_t;

    // Scaled divisor: stored field plus one unit of the integer part.
    function automatic logic [REG_W+1:0] scaled_div(input logic [REG_W-1:0] field,
                                                    input int unsigned      frac_w);
        logic [REG_W+1:0] unit;
        unit = (REG_W+2)'(1) << frac_w;
        return {2'b00, field} + unit;
    endfunction

endpackage

// File: rtl/tfd_trig.sv
module tfd_trig #(
    parameter int BUSY_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic allow_i,
    output logic busy_o,
    output logic apply_o
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end else if (start_i && allow_i) begin
            cnt_q <= CW'(BUSY_CYC);
        end
    end

    assign busy_o  = (cnt_q != '0);
    assign apply_o = (cnt_q == CW'(1));

    // R4: a commit that has started stays pending for more than one cycle
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> busy_o);

    // R4: once the staged values are applied, the pending bit clears
    a_r4_apply_clears: assert property (@(posedge clk) disable iff (rst)
        apply_o |=> !busy_o);

    // R6: a request made while the clock is off does not start a commit
    a_r6_drop_when_off: assert property (@(posedge clk) disable iff (rst)
        (start_i && !allow_i && !busy_o) |=> !busy_o);

endmodule

// File: rtl/tfd_prediv.sv
module tfd_prediv #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap   = (cnt_q >= div_i);
    assign tick_o = tick_i && wrap && !clr_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= wrap ? '0 : cnt_q + W'(1);
        end
    end

    // R9: the phase counter never runs past the programmed count
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (cnt_q <= div_i));

endmodule

// File: rtl/tfd_frac.sv
module tfd_frac #(
    parameter int DIV_W  = 8,
    parameter int FRAC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] field_i,
    output logic             tick_o
);
    localparam int AW = DIV_W + 2;

    logic [AW-1:0] unit;
    logic [AW-1:0] ds;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;
    logic          hit;

    assign unit = AW'(1) << FRAC_W;
    assign ds   = AW'(tfd_pkg::scaled_div(tfd_pkg::REG_W'(field_i), FRAC_W));
    assign sum  = acc_q + unit;
    assign hit  = (sum >= ds);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (tick_i) begin
            acc_q  <= hit ? sum - ds : sum;
            tick_o <= hit;
        end else begin
            tick_o <= 1'b0;
        end
    end

    // R3: the remainder always stays below the scaled divisor
    a_r3_acc_bound: assert property (@(posedge clk) disable iff (rst)
        acc_q < ds);

    // R1: divisor one passes every incoming tick
    a_r1_unity_pass: assert property (@(posedge clk) disable iff (rst)
        (field_i == '0 && tick_i && !clr_i) |=> tick_o);

    // R3: no output pulse without an incoming tick
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !tick_o);

endmodule

// File: rtl/trig_frac_clkdiv.sv
module trig_frac_clkdiv #(
    parameter int NUM_PAR    = 3,
    parameter int SEL_W      = 2,
    parameter int SEL_SHIFT  = 4,
    parameter int HAS_PREDIV = 1,
    parameter int PDIV_W     = 4,
    parameter int PDIV_SHIFT = 8,
    parameter int DIV_W      = 8,
    parameter int FRAC_W     = 3,
    parameter int DIV_SHIFT  = 4,
    parameter int SRC_BIT    = 0,
    parameter int MAIN_BIT   = 1,
    parameter int BUSY_CYC   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_on_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [31:0]        wr_data_i,
    input  logic [1:0]         rd_addr_i,
    output logic [31:0]        rd_data_o,
    input  logic [NUM_PAR-1:0] par_tick_i,
    output logic               tick_o
);
    import tfd_pkg::*;

    localparam logic [SEL_W-1:0] SEL_RST = {SEL_W{1'b1}};

    // staged and active configuration
    logic [SEL_W-1:0]  st_sel,  ac_sel;
    logic [PDIV_W-1:0] st_pdiv, ac_pdiv;
    logic [DIV_W-1:0]  st_div,  ac_div;

    reg_addr_e  waddr, raddr;
    trig_pair_t start, busy, apply;

    assign waddr = reg_addr_e'(wr_addr_i);
    assign raddr = reg_addr_e'(rd_addr_i);

    assign start.src  = wr_en_i && (waddr == A_TRIG) && wr_data_i[SRC_BIT];
    assign start.main = wr_en_i && (waddr == A_TRIG) && wr_data_i[MAIN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_sel  <= SEL_RST;
            st_pdiv <= '0;
            st_div  <= '0;
        end else if (wr_en_i && clk_on_i) begin
            if (waddr == A_SRC) begin
                st_sel  <= wr_data_i[SEL_SHIFT +: SEL_W];
                st_pdiv <= wr_data_i[PDIV_SHIFT +: PDIV_W];
            end
            if (waddr == A_DIV) begin
                st_div <= wr_data_i[DIV_SHIFT +: DIV_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_sel  <= SEL_RST;
            ac_pdiv <= '0;
            ac_div  <= '0;
        end else begin
            if (apply.src) begin
                ac_sel  <= st_sel;
                ac_pdiv <= st_pdiv;
            end
            if (apply.main) begin
                ac_div <= st_div;
            end
        end
    end

    tfd_trig #(.BUSY_CYC(BUSY_CYC)) u_trig_src (
        .clk(clk), .rst(rst), .start_i(start.src), .allow_i(clk_on_i),
        .busy_o(busy.src), .apply_o(apply.src)
    );

    tfd_trig #(.BUSY_CYC(BUSY_CYC)) u_trig_main (
        .clk(clk), .rst(rst), .start_i(start.main), .allow_i(clk_on_i),
        .busy_o(busy.main), .apply_o(apply.main)
    );

    // parent selection; out-of-range codes select nothing
    logic [NUM_PAR-1:0] hit;
    logic               sel_valid;
    logic               sel_tick;

    for (genvar g = 0; g < NUM_PAR; g++) begin : g_par
        assign hit[g] = par_tick_i[g] && (ac_sel == SEL_W'(g));
    end

    assign sel_valid = (int'(ac_sel) < NUM_PAR);
    assign sel_tick  = |hit;

    logic pre_tick;

    if (HAS_PREDIV != 0) begin : g_pre
        tfd_prediv #(.W(PDIV_W)) u_prediv (
            .clk(clk), .rst(rst), .clr_i(apply.src), .tick_i(sel_tick),
            .div_i(ac_pdiv), .tick_o(pre_tick)
        );
    end else begin : g_nopre
        assign pre_tick = sel_tick && !apply.src;
    end

    tfd_frac #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_frac (
        .clk(clk), .rst(rst), .clr_i(apply.main), .tick_i(pre_tick),
        .field_i(ac_div), .tick_o(tick_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (raddr)
            A_SRC: begin
                rd_data_o[SEL_SHIFT +: SEL_W]   = st_sel;
                rd_data_o[PDIV_SHIFT +: PDIV_W] = st_pdiv;
            end
            A_DIV:  rd_data_o[DIV_SHIFT +: DIV_W] = st_div;
            A_TRIG: begin
                rd_data_o[SRC_BIT]  = busy.src;
                rd_data_o[MAIN_BIT] = busy.main;
            end
            default: rd_data_o = '0;
        endcase
    end

    // R7: an unmapped selection never lets a pulse through
    a_r7_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |=> !tick_o);

    // R6: staged configuration is frozen while the clock is off
    a_r6_stage_frozen: assert property (@(posedge clk) disable iff (rst)
        !clk_on_i |=> ($stable(st_sel) && $stable(st_pdiv) && $stable(st_div)));

    // R5: the active divider moves only with a main commit
    a_r5_main_only: assert property (@(posedge clk) disable iff (rst)
        !apply.main |=> $stable(ac_div));

    // R5: the active source moves only with a source commit
    a_r5_src_only: assert property (@(posedge clk) disable iff (rst)
        !apply.src |=> ($stable(ac_sel) && $stable(ac_pdiv)));

endmodule

// File: tb/trig_frac_clkdiv_tb.sv
module trig_frac_clkdiv_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_on = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  par = '0;
    logic        tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int    exp_q[$];
    string tag_q[$];
    bit    win_on  = 0;
    bit    win_end = 0;
    int    win_cnt = 0;

    always #2 clk = ~clk;

    trig_frac_clkdiv u_dut (
        .clk(clk), .rst(rst), .clk_on_i(clk_on),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .par_tick_i(par), .tick_o(tick)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a; #0.5;
        v = int'(rd_data);
    endtask

    task automatic commit(input logic [31:0] bits);
        wr(2'd2, bits);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // expected pulse count from R3 and R9
    function automatic int expect_pulses(input int n, input int pdiv, input int field);
        int pre;
        pre = n / (pdiv + 1);
        return (pre * 8) / (field + 8);
    endfunction

    // driver: pushes the expected count, then applies the ticks
    task automatic window(input logic [2:0] mask, input int n, input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        win_on = 1;
        for (int i = 0; i < n; i++) begin
            par = mask;
            @(posedge clk); #1;
        end
        par = '0;
        repeat (3) @(posedge clk);
        #1;
        win_on = 0;
        win_end = 1;
        @(negedge clk); #1;
        win_end = 0;
    endtask

    // monitor: counts pulses, pops and compares at the end of each window
    always @(negedge clk) begin
        if (win_end) begin
            if (exp_q.size() != 0) chk(tag_q.pop_front(), win_cnt, exp_q.pop_front());
            win_cnt = 0;
        end else if (win_on && tick) begin
            win_cnt = win_cnt + 1;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset state
        rd(2'd0, v); chk("R10 src reg", v, 32'h30);
        rd(2'd1, v); chk("R10 div reg", v, 0);
        rd(2'd2, v); chk("R10 trig reg", v, 0);
        chk("R10 tick low", int'(tick), 0);
        // R7: reset selection names no parent
        window(3'b111, 20, 0, "R7 reset select quiet");

        clk_on = 1'b1;
        wr(2'd0, (1 << 4));
        wr(2'd1, 0);
        // R4: busy window of a commit
        wr(2'd2, 3);
        rd(2'd2, v); chk("R4 busy first", v, 3);
        @(posedge clk); #1;
        @(posedge clk); #1;
        rd(2'd2, v); chk("R4 busy third", v, 3);
        @(posedge clk); #1;
        rd(2'd2, v); chk("R4 done fourth", v, 0);
        window(3'b010, 40, expect_pulses(40, 0, 0), "R1 unity divisor");

        // R2: field 8 is divisor 2.0
        wr(2'd1, 8 << 4); commit(2);
        window(3'b010, 40, expect_pulses(40, 0, 8), "R2 divisor two");

        // R3: field 4 is divisor 1.5
        wr(2'd1, 4 << 4); commit(2);
        window(3'b010, 40, expect_pulses(40, 0, 4), "R3 divisor one and half");

        // R5: staged pre-divider waits for its own trigger
        wr(2'd1, 8 << 4); commit(2);
        wr(2'd0, (1 << 4) | (2 << 8)); commit(2);
        window(3'b010, 40, expect_pulses(40, 0, 8), "R5 main commit leaves source");
        commit(1);
        window(3'b010, 60, expect_pulses(60, 2, 8), "R9 predivide by three");

        // R8: only the selected parent counts
        wr(2'd0, (0 << 4) | (2 << 8)); commit(1);
        window(3'b010, 30, 0, "R8 other parent ignored");
        window(3'b001, 30, expect_pulses(30, 2, 8), "R8 selected parent");

        // R7: invalid selection code
        wr(2'd0, (3 << 4) | (2 << 8)); commit(1);
        window(3'b111, 30, 0, "R7 invalid code quiet");

        // R6: updates dropped while clock off
        wr(2'd0, (1 << 4) | (2 << 8)); commit(1);
        clk_on = 1'b0;
        wr(2'd0, 0);
        rd(2'd0, v); chk("R6 staged write dropped", v, 32'h210);
        wr(2'd2, 3);
        rd(2'd2, v); chk("R6 trigger reads zero", v, 0);
        repeat (4) @(posedge clk);
        #1 clk_on = 1'b1;
        window(3'b010, 30, expect_pulses(30, 2, 8), "R6 config unchanged");

        // R1: field 16 is divisor 3.0
        wr(2'd0, (1 << 4)); wr(2'd1, 16 << 4); commit(3);
        window(3'b010, 30, expect_pulses(30, 0, 16), "R1 divisor three");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule